// File: doc/BRIEF.md
# Minimal Load-Store RISC Core

This block is a single-cycle 32-bit processor for a five-operation subset: register add, register subtract, add with a signed 16-bit constant, load word and store word. Every clock cycle it fetches one instruction at the program counter, decodes it, reads two source registers, forms a sum or difference, and commits the result to the register file or to data memory. That commit happens on the same rising edge that moves the program counter forward by 4.

Instruction and data memories live outside the core, and each is reached through a plain word port. The instruction port is a byte address with a combinational read word. The data port carries a byte address, write data, a write strobe and a read strobe, and returns read data combinationally. A memory write lands on the rising clock edge. Words are big-endian: the byte at the word's own address is the most significant one. The core only ever moves whole words at addresses whose two low bits are zero. A debug read port returns any register, so a program's results can be compared against a model. Two sticky flags record unsupported encodings and misaligned accesses.

Top module: `lsr_core`

## Requirements
- R1: While `rst_n` is low, the fetch address is 0, every register reads 0 and both flags are clear. Execution starts on the third rising edge after `rst_n` is released, because the release passes through a two-stage synchronizer.
- R2: The fetch address equals the program counter, and the program counter grows by exactly 4 on every rising edge once execution has started.
- R3: An instruction with bits [31:26] = 0 and bits [5:0] = 32 writes rs + rt to rd. With bits [5:0] = 34 it writes rs − rt to rd. The fields are rs = [25:21], rt = [20:16] and rd = [15:11]. Bits [10:6] have no effect, and results wrap modulo 2^32.
- R4: Opcode 8 writes rs plus the sign-extended bits [15:0] to rt. The constant spans −32768 to +32767.
- R5: Opcode 35 forms the byte address rs + sign-extended [15:0] and writes the memory word at that address to rt.
- R6: Opcode 43 forms its address the same way and writes rt to the memory word there. A word at byte address A covers bytes A to A+3, and A holds the most significant byte.
- R7: Register 0 always reads 0, and a write aimed at it changes nothing.
- R8: Any other opcode, or opcode 0 with bits [5:0] other than 32 or 34, changes no register and no memory. It sets `illegal_flag`, which stays set until reset.
- R9: A load or store whose address has nonzero bits [1:0] makes no memory access and leaves the load destination unchanged. It sets `misalign_flag`, which stays set until reset.
- R10: `dbg_value` shows, in the same cycle, the register selected by `dbg_sel`, including results committed on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Word to store |
| dmem_we | output | 1 | Store strobe, taken on the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Word at `dmem_addr` |
| dbg_sel | input | 5 | Register index for the debug port |
| dbg_value | output | 32 | Contents of the selected register |
| illegal_flag | output | 1 | Sticky unsupported-encoding flag |
| misalign_flag | output | 1 | Sticky misaligned-access flag |

## Verification
The hardest situation to reach from the ports is a misaligned access whose address comes from a register value computed earlier in the program, rather than from a literal offset. In that case the load must leave a live destination untouched, and the store must leave the memory word as it was. The bench reaches it with pseudo-random programs. Each program first seeds registers 1 to 7 with random constants, then mixes base-register loads and stores, aligned loads and stores, arithmetic and unsupported encodings. A bench-side instruction model predicts every register, every memory word and both flags. Directed programs add the sign-extension extremes, a negative offset, wraparound, writes to register 0, and an unsupported encoding that would otherwise have changed a register.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned OPW  = 6;
  localparam int unsigned FNW  = 6;
  localparam int unsigned RAW  = 5;
  localparam int unsigned IMMW = 16;

  localparam logic [OPW-1:0] OP_RTYPE  = 6'd0;
  localparam logic [OPW-1:0] OP_ADDI   = 6'd8;
  localparam logic [OPW-1:0] OP_LOADW  = 6'd35;
  localparam logic [OPW-1:0] OP_STOREW = 6'd43;
  localparam logic [FNW-1:0] FN_ADD    = 6'd32;
  localparam logic [FNW-1:0] FN_SUB    = 6'd34;

  typedef struct packed {
    logic rf_we;      // instruction writes a register
    logic dst_is_rt;  // destination is the rt field, not rd
    logic use_imm;    // second operand is the extended constant
    logic alu_sub;    // subtract instead of add
    logic mem_rd;     // load
    logic mem_wr;     // store
    logic illegal;    // unsupported encoding
  } ctl_t;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output ctl_t            ctl,
  output logic [RAW-1:0]  rs,
  output logic [RAW-1:0]  rt,
  output logic [RAW-1:0]  rd,
  output logic [XLEN-1:0] imm_ext
);
  localparam int unsigned EXTW = XLEN - IMMW;

  logic [OPW-1:0]  op;
  logic [FNW-1:0]  funct;
  logic [IMMW-1:0] imm;

  assign op      = instr[XLEN-1 -: OPW];
  assign rs      = instr[XLEN-OPW-1 -: RAW];
  assign rt      = instr[XLEN-OPW-RAW-1 -: RAW];
  assign rd      = instr[XLEN-OPW-2*RAW-1 -: RAW];
  assign funct   = instr[FNW-1:0];
  assign imm     = instr[IMMW-1:0];
  assign imm_ext = {{EXTW{imm[IMMW-1]}}, imm};

  always_comb begin
    ctl = '0;
    case (op)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.rf_we   = 1'b1;
          ctl.alu_sub = (funct == FN_SUB);
        end else begin
          ctl.illegal = 1'b1;
        end
      end
      OP_ADDI: begin
        ctl.rf_we     = 1'b1;
        ctl.dst_is_rt = 1'b1;
        ctl.use_imm   = 1'b1;
      end
      OP_LOADW: begin
        ctl.rf_we     = 1'b1;
        ctl.dst_is_rt = 1'b1;
        ctl.use_imm   = 1'b1;
        ctl.mem_rd    = 1'b1;
      end
      OP_STOREW: begin
        ctl.use_imm   = 1'b1;
        ctl.mem_wr    = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [DW-1:0] rc_data
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[waddr] = wdata;
    regs_d[0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  regs_q <= '0;
    else if (we) regs_q <= regs_d;
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign rc_data = regs_q[rc_addr];

  // R7: a write aimed at register 0 leaves the whole file unchanged
  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> $stable(regs_q));

  // R10: a committed write is visible on the read side one edge later
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/lsr_alu.sv
module lsr_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  input  logic [RAW-1:0]  dbg_sel,
  output logic [XLEN-1:0] dbg_value,
  output logic            illegal_flag,
  output logic            misalign_flag
);
  localparam int ALIGNW = $clog2(PC_STEP);

  // reset: asserted asynchronously, released on the clock
  logic sync_meta_q, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {core_rst_n, sync_meta_q} <= 2'b00;
    else        {core_rst_n, sync_meta_q} <= {sync_meta_q, 1'b1};
  end

  // program counter
  logic [XLEN-1:0] pc_q, pc_d;
  always_comb pc_d = pc_q + XLEN'(PC_STEP);
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= XLEN'(RESET_PC);
    else             pc_q <= pc_d;
  end
  assign imem_addr = pc_q;

  // decode
  ctl_t            ctl;
  logic [RAW-1:0]  rs, rt, rd;
  logic [XLEN-1:0] imm_ext;
  lsr_decode #(.XLEN(XLEN)) u_decode (
    .instr(imem_rdata), .ctl(ctl), .rs(rs), .rt(rt), .rd(rd), .imm_ext(imm_ext)
  );

  // register file
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata, rs_data, rt_data;
  lsr_regfile #(.DW(XLEN), .AW(RAW)) u_regfile (
    .clk(clk), .rst_n(core_rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(rs), .ra_data(rs_data), .rb_addr(rt), .rb_data(rt_data),
    .rc_addr(dbg_sel), .rc_data(dbg_value)
  );

  // execute
  logic [XLEN-1:0] opnd_b, alu_y;
  assign opnd_b = ctl.use_imm ? imm_ext : rt_data;
  lsr_alu #(.W(XLEN)) u_alu (.a(rs_data), .b(opnd_b), .sub(ctl.alu_sub), .y(alu_y));

  logic mem_op, misal;
  assign mem_op = ctl.mem_rd | ctl.mem_wr;
  assign misal  = mem_op & (|alu_y[ALIGNW-1:0]);

  // commit enables
  assign rf_we    = core_rst_n & ctl.rf_we & ~(ctl.mem_rd & misal);
  assign rf_waddr = ctl.dst_is_rt ? rt : rd;
  assign rf_wdata = ctl.mem_rd ? dmem_rdata : alu_y;

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_data;
  assign dmem_we    = core_rst_n & ctl.mem_wr & ~misal;
  assign dmem_re    = core_rst_n & ctl.mem_rd & ~misal;

  // sticky flags
  logic ill_q, ill_d, mis_q, mis_d;
  always_comb begin
    ill_d = ill_q | ctl.illegal;
    mis_d = mis_q | misal;
  end
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ill_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      ill_q <= ill_d;
      mis_q <= mis_d;
    end
  end
  assign illegal_flag  = ill_q;
  assign misalign_flag = mis_q;

  // R2: fetch address steps by the word size each edge
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> imem_addr == $past(imem_addr) + XLEN'(PC_STEP));

  // R3: the subtractor output added back to rt gives rs
  assert_sub_inverse_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.alu_sub |-> (alu_y + rt_data) == rs_data);

  // R8: unsupported encodings touch neither register file nor memory
  assert_illegal_inert_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.illegal |-> (!rf_we && !dmem_we && !dmem_re));

  // R8: decoded classes never overlap
  assert_decode_exclusive_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({ctl.mem_rd, ctl.mem_wr, ctl.illegal}));

  // R8: illegal flag is sticky
  assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    illegal_flag |=> illegal_flag);

  // R9: every memory strobe carries a word-aligned address
  assert_access_aligned_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dmem_we || dmem_re) |-> dmem_addr[ALIGNW-1:0] == '0);

  // R9: misalign flag is sticky
  assert_misalign_sticky_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    misalign_flag |=> misalign_flag);
endmodule

// File: tb/lsr_core_bench.sv
`timescale 1ns/1ps
module lsr_core_bench;
  localparam logic [31:0] NOP = 32'h0000_0020;  // add r0,r0,r0

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_value;
  logic        dmem_we, dmem_re, illegal_flag, misalign_flag;
  logic [4:0]  dbg_sel = '0;

  always #5 clk = ~clk;

  lsr_core u_lsr_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata), .dbg_sel(dbg_sel), .dbg_value(dbg_value),
    .illegal_flag(illegal_flag), .misalign_flag(misalign_flag)
  );

  // external memories
  logic [31:0] im [256];
  logic [31:0] dm [64];
  assign imem_rdata = im[imem_addr[9:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  // reference model state
  logic [31:0] ref_rf [32];
  logic [31:0] ref_dm [64];
  logic        ref_ill, ref_mis;

  logic [31:0] prog [64];
  int          plen;
  int          n_checks = 0, n_fail = 0;
  bit          finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic ref_step(input logic [31:0] w);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd;
    logic [31:0] sx, ea;
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    sx = {{16{w[15]}}, w[15:0]};
    ea = ref_rf[rs] + sx;
    case (op)
      6'd0: begin
        if (w[5:0] == 6'd32)      begin if (rd != 0) ref_rf[rd] = ref_rf[rs] + ref_rf[rt]; end
        else if (w[5:0] == 6'd34) begin if (rd != 0) ref_rf[rd] = ref_rf[rs] - ref_rf[rt]; end
        else ref_ill = 1'b1;
      end
      6'd8:  if (rt != 0) ref_rf[rt] = ea;
      6'd35: if (ea[1:0] != 2'b00) ref_mis = 1'b1; else if (rt != 0) ref_rf[rt] = ref_dm[ea[7:2]];
      6'd43: if (ea[1:0] != 2'b00) ref_mis = 1'b1; else ref_dm[ea[7:2]] = ref_rf[rt];
      default: ref_ill = 1'b1;
    endcase
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    dbg_sel = 5'(r);
    #1;
    v = dbg_value;
  endtask

  // load, reset, run, compare against the model
  task automatic run_program();
    logic [31:0] v, p;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) im[i] = (i < plen) ? prog[i] : NOP;
    for (int i = 0; i < 64; i++) begin dm[i] = rnd(); ref_dm[i] = dm[i]; end
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    ref_ill = 1'b0; ref_mis = 1'b0;
    for (int i = 0; i < plen; i++) ref_step(prog[i]);
    @(negedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
    check({illegal_flag, misalign_flag} == 2'b00, "R1 reset flags",
          {30'h0, illegal_flag, misalign_flag}, 32'h0);
    read_reg(5, v);
    check(v == 32'h0, "R1 reset reg", v, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 hold during sync", imem_addr, 32'h0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      p = imem_addr;
      @(negedge clk);
      check(imem_addr == p + 32'd4, "R2 pc step", imem_addr, p + 32'd4);
    end
    repeat (plen + 2) @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check(v == ref_rf[r], "R10 register vs model", v, ref_rf[r]);
    end
    for (int i = 0; i < 64; i++)
      check(dm[i] == ref_dm[i], "R6 memory vs model", dm[i], ref_dm[i]);
    check(illegal_flag == ref_ill, "R8 illegal flag", 32'(illegal_flag), 32'(ref_ill));
    check(misalign_flag == ref_mis, "R9 misalign flag", 32'(misalign_flag), 32'(ref_mis));
  endtask

  task automatic expect_reg(input int r, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    read_reg(r, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // directed program: arithmetic, extremes, register 0, misalignment
    plen = 0;
    put(enc_i(8, 0, 1, -5));          // r1 = -5
    put(enc_i(8, 0, 2, 32767));       // r2 = 0x7fff
    put(enc_r(1, 2, 3, 7, 32));       // r3 = r1 + r2, shamt nonzero
    put(enc_r(1, 2, 4, 0, 34));       // r4 = r1 - r2
    put(enc_i(43, 0, 3, 8));          // mem[8] = r3
    put(enc_i(35, 0, 5, 8));          // r5 = mem[8]
    put(enc_i(8, 1, 0, 9));           // write to r0
    put(enc_r(0, 2, 6, 0, 32));       // r6 = r0 + r2
    put(enc_i(8, 0, 7, 1));           // r7 = 1
    put(enc_i(35, 7, 6, 0));          // misaligned load into r6
    put(enc_i(43, 0, 1, 3));          // misaligned store
    put(enc_i(8, 0, 8, -32768));      // r8 = -32768
    put(enc_r(0, 8, 9, 0, 34));       // r9 = 0 - r8
    put(enc_i(8, 0, 10, -1));
    put(enc_i(8, 0, 11, 1));
    put(enc_r(10, 11, 12, 0, 32));    // wrap to 0
    put(enc_i(8, 0, 13, 64));
    put(enc_i(43, 13, 4, -4));        // negative offset store to byte 60
    put(enc_i(35, 13, 14, -4));       // load it back
    run_program();
    expect_reg(1, 32'hFFFF_FFFB, "R4 negative constant");
    expect_reg(2, 32'h0000_7FFF, "R4 max constant");
    expect_reg(3, 32'h0000_7FFA, "R3 add with shamt ignored");
    expect_reg(4, 32'hFFFF_7FFC, "R3 subtract");
    expect_reg(5, 32'h0000_7FFA, "R5 load word");
    expect_reg(0, 32'h0, "R7 register zero");
    expect_reg(6, 32'h0000_7FFF, "R9 misaligned load keeps dest");
    expect_reg(8, 32'hFFFF_8000, "R4 min constant");
    expect_reg(9, 32'h0000_8000, "R3 subtract from zero");
    expect_reg(12, 32'h0, "R3 wraparound");
    expect_reg(14, 32'hFFFF_7FFC, "R5 negative offset");
    check(dm[2] == 32'h0000_7FFA, "R6 store word", dm[2], 32'h0000_7FFA);
    check(dm[15] == 32'hFFFF_7FFC, "R6 negative offset store", dm[15], 32'hFFFF_7FFC);
    check(misalign_flag && !illegal_flag, "R9 only misalign raised",
          {30'h0, illegal_flag, misalign_flag}, 32'h1);

    // unsupported encodings
    plen = 0;
    put(enc_i(8, 0, 1, 5));
    put({6'd2, 26'h0000_123});
    put(enc_r(1, 1, 1, 0, 33));
    put(enc_i(8, 1, 2, 1));
    run_program();
    expect_reg(1, 32'd5, "R8 unsupported funct writes nothing");
    expect_reg(2, 32'd6, "R8 execution continues");
    check(illegal_flag && !misalign_flag, "R8 only illegal raised",
          {30'h0, illegal_flag, misalign_flag}, 32'h2);

    // pseudo-random programs
    for (int t = 0; t < 8; t++) begin
      plen = 0;
      for (int k = 1; k < 8; k++) put(enc_i(8, 0, k, int'(rnd() >> 16)));
      for (int k = 0; k < 32; k++) begin
        logic [31:0] r;
        int sel;
        r = rnd();
        sel = int'(rnd() % 9);
        case (sel)
          0, 8: put(enc_r(r[2:0], r[5:3], r[8:6], r[13:9], 32));
          1: put(enc_r(r[2:0], r[5:3], r[8:6], r[13:9], 34));
          2: put(enc_i(8, r[2:0], r[5:3], r[31:16]));
          3: put(enc_i(35, r[2:0], r[5:3], r[31:16]));
          4: put(enc_i(43, r[2:0], r[5:3], r[31:16]));
          5: put(enc_i(35, 0, r[5:3], {r[23:18], 2'b00}));
          6: put(enc_i(43, 0, r[5:3], {r[23:18], 2'b00}));
          default: begin
            if (r[31:30] != 2'b00) put(enc_i(35, 0, r[5:3], {r[23:18], 2'b00}));
            else if (r[15]) put(enc_r(r[2:0], r[5:3], r[8:6], 0,
                                      (r[21:16] == 6'd32 || r[21:16] == 6'd34) ? 33 : int'(r[21:16])));
            else begin
              logic [5:0] op;
              op = r[27:22];
              if (op == 6'd0 || op == 6'd8 || op == 6'd35 || op == 6'd43) op = op + 6'd1;
              put({op, r[25:0]});
            end
          end
        endcase
      end
      run_program();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule